// File: doc/BRIEF.md
# Two-Dimensional Bus Request Arbiter

This block holds the pending bus requests of up to 32 backplane slots on five request levels at once and names one winner every cycle. Four levels carry interrupt requests for bus levels 4 to 7, and the fifth carries direct memory access. Priority is decided on two coordinates: the highest pending level wins first, and within that level the lowest slot number wins, because that slot sits closest to the processor.

Requesters raise a one-cycle set strobe for their level and slot, and may withdraw it with a clear strobe. The bus logic reads the winner and pulses an accept input when it takes the grant. The accepted request is then removed from its level's bitmap, and the next winner shows on the following cycle. Every level keeps its own active-slot bitmap, and a lowest-set-bit search runs on each bitmap in parallel.

Top module: `bus_req_arbiter`

## Requirements
- R1: After reset every bitmap is empty, `active_o` is all zero, `valid_o` is 0, and `level_o` and `slot_o` are 0.
- R2: A set strobe on bit `l*32+s` of `set_i` (level index `l`, slot `s`) makes bit `l*32+s` of `active_o` read 1 from the cycle after the strobe.
- R3: A clear strobe on a bit of `clr_i`, with no set on the same bit, makes that bit of `active_o` read 0 from the next cycle.
- R4: When a set and a clear hit the same level and slot in the same cycle, the bit reads 1 afterwards.
- R5: `level_o` is the highest level index that has any active bit. Index 4 is the DMA level and the highest priority. Interrupt level n uses index n-4, so level 4 is index 0 and level 7 is index 3.
- R6: `slot_o` is the lowest active slot number within the level shown on `level_o`.
- R7: `accept_i` high while `valid_o` is high clears exactly the winning bit on the next cycle and leaves every other bit as it was.
- R8: `accept_i` while `valid_o` is low has no effect on `active_o`.
- R9: Whenever no bit is active, `valid_o` is 0 and `level_o` and `slot_o` read 0. Otherwise `valid_o` is 1.
- R10: A set strobe on the winning bit in the same cycle as an accept keeps that bit active.
- R11: The levels are independent: strobes on one level never change the bits of another level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 160 | Set strobes, bit `l*32+s` for level index `l` and slot `s` |
| clr_i | input | 160 | Clear strobes, same bit layout as `set_i` |
| accept_i | input | 1 | The current winner is taken |
| valid_o | output | 1 | A winner exists |
| level_o | output | 3 | Level index of the winner |
| slot_o | output | 5 | Slot number of the winner |
| active_o | output | 160 | All active requests, same bit layout as `set_i` |

## Verification
On every cycle the assertions check the following rules:
- the winner is an active bit;
- no level above the winner holds any bit;
- no lower slot in the winning level is set;
- the outputs rest at zero while the arbiter is idle;
- every strobed set lands;
- every unopposed clear and every accepted winner is removed;
- an accept with no winner leaves the bitmaps unchanged.

Other properties can only be shown by the bench scenarios. These are draining order over long sequences, the independence of levels under mixed traffic, and the exact mask contents after each step. The bench compares the mask contents against an arithmetic model, both in full sweeps over every level and slot and in pseudo-random traffic.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned DEF_LEVELS = 5;
  localparam int unsigned DEF_SLOTS  = 32;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/level_bitmap.sv
module level_bitmap #(
  parameter int unsigned NUM_SLOTS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  input  logic [NUM_SLOTS-1:0] grant_clr_i,
  output logic [NUM_SLOTS-1:0] bits_o
);
  logic [NUM_SLOTS-1:0] bits_q, bits_d;

  // set dominates both clear sources
  always_comb bits_d = (bits_q & ~(clr_i | grant_clr_i)) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/lowest_set_finder.sv
module lowest_set_finder #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IW   = arb_pkg::idx_w(WIDTH)
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IW'(i);
    end
  end

  assign found_o = |bits_i;
endmodule

// File: rtl/level_picker.sv
module level_picker #(
  parameter int unsigned NUM_LEVELS = 5,
  parameter int unsigned SW         = 5,
  localparam int unsigned LW        = arb_pkg::idx_w(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0]    found_i,
  input  logic [NUM_LEVELS*SW-1:0] slot_idx_i,
  output logic                     valid_o,
  output logic [LW-1:0]            level_o,
  output logic [SW-1:0]            slot_o
);
  // ascending scan: last hit is the highest level
  always_comb begin
    valid_o = 1'b0;
    level_o = '0;
    slot_o  = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (found_i[l]) begin
        valid_o = 1'b1;
        level_o = LW'(l);
        slot_o  = slot_idx_i[l*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/bus_req_arbiter.sv
module bus_req_arbiter #(
  parameter int unsigned NUM_LEVELS = arb_pkg::DEF_LEVELS,
  parameter int unsigned NUM_SLOTS  = arb_pkg::DEF_SLOTS,
  localparam int unsigned N         = NUM_LEVELS * NUM_SLOTS,
  localparam int unsigned LW        = arb_pkg::idx_w(NUM_LEVELS),
  localparam int unsigned SW        = arb_pkg::idx_w(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  input  logic          accept_i,
  output logic          valid_o,
  output logic [LW-1:0] level_o,
  output logic [SW-1:0] slot_o,
  output logic [N-1:0]  active_o
);
  logic [NUM_LEVELS-1:0]    found;
  logic [NUM_LEVELS*SW-1:0] slot_idx;
  logic [N-1:0]             grant_clr;
  logic                     grant_fire;

  assign grant_fire = accept_i & valid_o;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic [NUM_SLOTS-1:0] lvl_bits;

    assign grant_clr[l*NUM_SLOTS +: NUM_SLOTS] =
      (grant_fire && level_o == LW'(l)) ? (NUM_SLOTS'(1) << slot_o) : '0;

    level_bitmap #(.NUM_SLOTS(NUM_SLOTS)) u_map (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (set_i[l*NUM_SLOTS +: NUM_SLOTS]),
      .clr_i       (clr_i[l*NUM_SLOTS +: NUM_SLOTS]),
      .grant_clr_i (grant_clr[l*NUM_SLOTS +: NUM_SLOTS]),
      .bits_o      (lvl_bits)
    );

    lowest_set_finder #(.WIDTH(NUM_SLOTS)) u_find (
      .bits_i  (lvl_bits),
      .found_o (found[l]),
      .idx_o   (slot_idx[l*SW +: SW])
    );

    assign active_o[l*NUM_SLOTS +: NUM_SLOTS] = lvl_bits;
  end

  level_picker #(.NUM_LEVELS(NUM_LEVELS), .SW(SW)) u_pick (
    .found_i    (found),
    .slot_idx_i (slot_idx),
    .valid_o    (valid_o),
    .level_o    (level_o),
    .slot_o     (slot_o)
  );
endmodule

// File: rtl/bus_req_arbiter_chk.sv
module bus_req_arbiter_chk #(
  parameter int unsigned NUM_LEVELS = 5,
  parameter int unsigned NUM_SLOTS  = 32,
  localparam int unsigned N         = NUM_LEVELS * NUM_SLOTS,
  localparam int unsigned LW        = arb_pkg::idx_w(NUM_LEVELS),
  localparam int unsigned SW        = arb_pkg::idx_w(NUM_SLOTS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  set_i,
  input logic [N-1:0]  clr_i,
  input logic          accept_i,
  input logic          valid_o,
  input logic [LW-1:0] level_o,
  input logic [SW-1:0] slot_o,
  input logic [N-1:0]  active_o
);
  int                   win_idx;
  logic [NUM_SLOTS-1:0] win_bits;
  logic [NUM_SLOTS-1:0] below_mask;
  logic [N-1:0]         above_bits;

  assign win_idx    = int'(level_o) * NUM_SLOTS + int'(slot_o);
  assign win_bits   = active_o[int'(level_o)*NUM_SLOTS +: NUM_SLOTS];
  assign below_mask = (NUM_SLOTS'(1) << slot_o) - NUM_SLOTS'(1);
  assign above_bits = active_o >> ((int'(level_o) + 1) * NUM_SLOTS);

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o == (|active_o)) && (!valid_o -> (level_o == '0 && slot_o == '0)));
  // R5
  top_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (active_o[win_idx] && above_bits == '0));
  // R6
  low_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((win_bits & below_mask) == '0));
  // R2
  set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~active_o) == '0));
  // R3
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_i) & ~$past(set_i) & active_o) == '0));
  // R7
  accept_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && accept_i && !set_i[win_idx]) |=> !active_o[$past(win_idx)]);
  // R8
  idle_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && accept_i && set_i == '0 && clr_i == '0) |=> $stable(active_o));
endmodule

bind bus_req_arbiter bus_req_arbiter_chk #(
  .NUM_LEVELS(NUM_LEVELS), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .clr_i(clr_i),
  .accept_i(accept_i), .valid_o(valid_o), .level_o(level_o),
  .slot_o(slot_o), .active_o(active_o)
);

// File: tb/sim_bus_req_arbiter.sv
module sim_bus_req_arbiter;
  localparam int L = 5;
  localparam int S = 32;
  localparam int N = L * S;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] set_i = '0;
  logic [N-1:0] clr_i = '0;
  logic         accept_i = 1'b0;
  logic         valid_o;
  logic [2:0]   level_o;
  logic [4:0]   slot_o;
  logic [N-1:0] active_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [N-1:0] model = '0;

  always #5 clk_i = ~clk_i;

  bus_req_arbiter u0 (.*);

  function automatic void exp_win(input logic [N-1:0] m, output logic v,
                                  output int lv, output int sl);
    v = 0; lv = 0; sl = 0;
    for (int l = L - 1; l >= 0; l--)
      for (int s = 0; s < S; s++)
        if (!v && m[l*S+s]) begin v = 1; lv = l; sl = s; end
  endfunction

  function automatic logic [N-1:0] bit_at(input int l, input int s);
    logic [N-1:0] r = '0;
    r[l*S+s] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req);
    logic v; int lv, sl;
    exp_win(model, v, lv, sl);
    total++;
    if (active_o !== model) begin
      bad++; $display("FAIL %s active act=%h exp=%h", req, active_o, model);
    end
    total++;
    if (valid_o !== v || int'(level_o) != lv || int'(slot_o) != sl) begin
      bad++;
      $display("FAIL %s winner act=%b/%0d/%0d exp=%b/%0d/%0d",
               req, valid_o, level_o, slot_o, v, lv, sl);
    end
  endtask

  // drive at negedge, update model, sample at next negedge
  task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] c,
                     input logic a, input string req);
    logic v; int lv, sl;
    logic [N-1:0] g = '0;
    exp_win(model, v, lv, sl);
    if (a && v) g = bit_at(lv, sl);
    set_i = s; clr_i = c; accept_i = a;
    model = (model & ~c & ~g) | s;
    @(negedge clk_i);
    set_i = '0; clr_i = '0; accept_i = 1'b0;
    check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9");

    // R2 R5 R6 R7: every single bit, set then accept
    for (int l = 0; l < L; l++)
      for (int s = 0; s < S; s++) begin
        cyc(bit_at(l, s), '0, 1'b0, "R2");
        cyc('0, '0, 1'b1, "R7");
      end

    // R5: slot 31 per level, climbing, then drain downward
    for (int l = 0; l < L; l++) cyc(bit_at(l, S - 1), '0, 1'b0, "R5");
    for (int l = 0; l < L; l++) cyc('0, '0, 1'b1, "R5");

    // R6: fill level 2, drain in slot order
    begin
      logic [N-1:0] f = '0;
      f[2*S +: S] = '1;
      cyc(f, '0, 1'b0, "R6");
    end
    for (int s = 0; s < S; s++) cyc('0, '0, 1'b1, "R6");

    // R8: accept with nothing pending
    cyc('0, '0, 1'b1, "R8");
    cyc('0, '0, 1'b1, "R8");

    // R3 / R4
    cyc(bit_at(1, 3) | bit_at(1, 9), '0, 1'b0, "R2");
    cyc('0, bit_at(1, 3), 1'b0, "R3");
    cyc(bit_at(1, 9), bit_at(1, 9), 1'b0, "R4");
    cyc(bit_at(0, 7), bit_at(0, 7), 1'b0, "R4");

    // R11: clear across level 1 leaves others
    cyc(bit_at(0, 4) | bit_at(3, 20) | bit_at(4, 0), '0, 1'b0, "R11");
    begin
      logic [N-1:0] c = '0;
      c[1*S +: S] = '1;
      cyc('0, c, 1'b0, "R11");
    end

    // R10: re-set winner while accepting
    cyc(bit_at(4, 0), '0, 1'b1, "R10");
    cyc('0, '0, 1'b1, "R7");

    // mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] s = '0, c = '0;
      for (int b = 0; b < N; b++) begin
        s[b] = ($urandom % 50) == 0;
        c[b] = ($urandom % 40) == 0;
      end
      cyc(s, c, ($urandom % 2) == 1, "R11");
    end
    for (int k = 0; k < 200; k++) cyc('0, '0, 1'b1, "R7");
    check("R9");

    finish_run();
  end
endmodule